// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of a successive-approximation analog-to-digital converter. Software programs it through four byte-wide registers. It runs a binary search over a parameterised number of result bits. On each step it presents a trial code to an external DAC and takes a single comparator bit back. When the search ends it stores the result, which can be read right-aligned for full precision or left-aligned for 8-bit use. It then sets a completion flag, and that flag can drive an interrupt line.

A conversion can start in three ways. Software can write a start bit. A rising edge on a selectable trigger input can start one. In free-running mode the block restarts as soon as the previous conversion finishes. All timing is counted in half periods of a converter clock, whose half period is `2^psel` system clocks. This lets the fractional lengths come out exact: 38.5 converter clocks for the first conversion after enabling, 15.5 for triggered ones and 14.5 for manual ones. The channel number goes to an external multiplexer and is latched when the input is sampled. A low-byte read freezes the result pair until the high byte has been read.

Top module: `sar_conv_ctrl`

## Requirements
- R1: Register map at `addr`: 0 control (bit0 enable, bit1 start/busy, bit2 auto-trigger, bit3 done flag, bit4 interrupt enable, bits7:5 prescale select `psel`), 1 config (bits3:0 channel, bit4 left-align, bits7:5 trigger select), 2 result low byte, 3 result high byte. After reset every register reads 0, and `irq`, `dac_code` and `chan_sel` are 0.
- R2: A control write with enable and start set launches one conversion lasting 29 half periods. Control bit1 reads 1 while it runs and 0 afterwards. A start written during a conversion is ignored.
- R3: The first conversion started after enable goes from 0 to 1 lasts 77 half periods.
- R4: With auto-trigger set and trigger select k≥1, a rising edge on `trig_in[k-1]` starts a conversion of 31 half periods. Edges on other inputs, and edges seen while a conversion runs, start nothing.
- R5: With auto-trigger set and trigger select 0, a new conversion begins one system clock after each completion. Clearing auto-trigger stops the restarts.
- R6: The search tests bits from MSB to LSB, one per converter clock. Each bit is kept only when `cmp_in` is 1, meaning the input is at or above `dac_code`. The stored result is the largest code not above the input.
- R7: With left-align clear, the high byte is {zeros, result[9:8]} and the low byte is result[7:0]. With it set, the high byte is result[9:2] and the low byte is {result[1:0], 6'b0}.
- R8: The done flag sets at completion and is cleared by writing 1 to control bit3. `irq` is high only while both the flag and interrupt enable are set.
- R9: A half period is `2^psel` system clocks, so a manual conversion at `psel`=2 takes 116 clocks.
- R10: `chan_sel` takes the configured channel at the sampling instant, 22 half periods before completion. A channel written after that instant takes effect in the next conversion.
- R11: A low-byte read locks both result bytes until the high byte is read. A conversion that completes while they are locked leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives the result lock) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| trig_in | input | N_TRIG (4) | Trigger event inputs |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| dac_code | output | RES_W (10) | Trial code to the DAC |
| chan_sel | output | CHAN_W (4) | Latched channel for the multiplexer |
| irq | output | 1 | Completion interrupt request |

## Verification
The bench builds the block with a 10-bit result, a 4-bit channel and two trigger inputs, and keeps the default half-period counts. With two trigger inputs, select values that point at an input, at the unselected input and beyond the last input can all be reached. Because `psel` is 0, each conversion finishes within a few dozen clocks, so cycle-exact lengths of 29, 31 and 77 can be counted directly. One run at `psel`=2 checks the scaling. An ideal comparator model fed from a bench-side input value lets every table entry predict its full result and both alignments.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
   localparam int PS_W = 3;
   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_CFG  = 2'd1;
   localparam logic [1:0] A_LO   = 2'd2;
   localparam logic [1:0] A_HI   = 2'd3;
   localparam int C_EN   = 0;
   localparam int C_GO   = 1;
   localparam int C_AUTO = 2;
   localparam int C_FLAG = 3;
   localparam int C_IE   = 4;
   localparam int C_PS   = 5;
   localparam int F_LADJ = 4;
   localparam int F_TSEL = 5;
   typedef enum logic [1:0] {K_MAN, K_AUTO, K_FIRST} kind_t;
endpackage

// File: rtl/sar_halftick.sv
`timescale 1ns/1ps
module sar_halftick #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int CNT_W = (1 << SEL_W) - 1;

   if (SEL_W < 1 || SEL_W > 5) begin : g_bad_sel
      $error("sar_halftick: SEL_W out of range");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;

   always_comb begin
      lim  = CNT_W'((64'd1 << sel) - 64'd1);
      tick = run && (cnt == lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!run || tick) cnt <= '0;
      else                   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sar_engine.sv
`timescale 1ns/1ps
module sar_engine
   import sar_pkg::*;
#(
   parameter int RES_W      = 10,
   parameter int CHAN_W     = 4,
   parameter int FIRST_HALF = 77,
   parameter int AUTO_HALF  = 31,
   parameter int MAN_HALF   = 29
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  kind_t             kind,
   input  logic              tick,
   input  logic              cmp_in,
   input  logic [CHAN_W-1:0] chan_req,
   output logic              busy,
   output logic              done,
   output logic [RES_W-1:0]  code,
   output logic [CHAN_W-1:0] chan_sel
);
   localparam int SAMP = 2 * RES_W + 2;
   localparam int RW   = $clog2(FIRST_HALF + 1);

   if (MAN_HALF < SAMP || AUTO_HALF < SAMP || FIRST_HALF < SAMP) begin : g_bad_len
      $error("sar_engine: conversion shorter than sample plus search");
   end

   logic [RW-1:0]    rem;
   logic [RW-1:0]    len;
   logic [RW-1:0]    idx;
   logic [RES_W-1:0] bitsel;
   logic             in_sar;

   always_comb begin
      unique case (kind)
         K_FIRST: len = RW'(FIRST_HALF);
         K_AUTO:  len = RW'(AUTO_HALF);
         default: len = RW'(MAN_HALF);
      endcase
      idx    = (rem - RW'(2)) >> 1;
      bitsel = RES_W'(1) << idx;
      in_sar = (rem >= RW'(2)) && (rem <= RW'(2 * RES_W + 1));
      done   = busy && tick && (rem == RW'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         rem      <= '0;
         code     <= '0;
         chan_sel <= '0;
      end else if (start && !busy) begin
         busy <= 1'b1;
         rem  <= len;
         code <= '0;
      end else if (busy && tick) begin
         rem <= rem - 1'b1;
         if (rem == RW'(SAMP)) chan_sel <= chan_req;
         if (in_sar) begin
            if (rem[0])      code <= code | bitsel;
            else if (!cmp_in) code <= code & ~bitsel;
         end
         if (rem == RW'(1)) busy <= 1'b0;
      end
   end

   // R6: the trial code only moves on a half-period strobe
   a_r6_dac_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !tick |=> $stable(code));
   // R10: channel only changes at the sampling instant
   a_r10_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && tick && rem == RW'(SAMP)) |=> $stable(chan_sel));
   // R2: a running conversion is not cut short or restarted
   a_r2_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done |=> busy);
endmodule

// File: rtl/sar_conv_ctrl.sv
`timescale 1ns/1ps
module sar_conv_ctrl
   import sar_pkg::*;
#(
   parameter int RES_W      = 10,
   parameter int CHAN_W     = 4,
   parameter int N_TRIG     = 4,
   parameter int FIRST_HALF = 77,
   parameter int AUTO_HALF  = 31,
   parameter int MAN_HALF   = 29
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic [N_TRIG-1:0] trig_in,
   input  logic              cmp_in,
   output logic [RES_W-1:0]  dac_code,
   output logic [CHAN_W-1:0] chan_sel,
   output logic              irq
);
   if (RES_W < 9 || RES_W > 16) begin : g_bad_res
      $error("sar_conv_ctrl: RES_W must be 9..16");
   end
   if (CHAN_W < 1 || CHAN_W > 4) begin : g_bad_chan
      $error("sar_conv_ctrl: CHAN_W must be 1..4");
   end
   if (N_TRIG < 1 || N_TRIG > 7) begin : g_bad_trig
      $error("sar_conv_ctrl: N_TRIG must be 1..7");
   end

   logic              en_q, auto_q, ie_q, flag_q, ladj_q, locked_q, first_q;
   logic [PS_W-1:0]   psel_q;
   logic [2:0]        tsel_q;
   logic [CHAN_W-1:0] chan_q;
   logic [RES_W-1:0]  res_q;
   logic [N_TRIG-1:0] trig_prev;

   logic ctrl_wr, cfg_wr, en_rise, first_now, man_start, auto_start, sel_rise;
   logic start, busy, done, tick, lock_now;
   logic [7:0]  rise_ext;
   logic [15:0] right_al, left_al, shown;
   kind_t kind;

   always_comb begin
      ctrl_wr    = wr_en && (addr == A_CTRL);
      cfg_wr     = wr_en && (addr == A_CFG);
      en_rise    = ctrl_wr && wdata[C_EN] && !en_q;
      first_now  = first_q || en_rise;
      man_start  = ctrl_wr && wdata[C_EN] && wdata[C_GO];
      rise_ext   = 8'({trig_in & ~trig_prev, 1'b0});
      sel_rise   = (32'(tsel_q) <= N_TRIG) && rise_ext[tsel_q];
      auto_start = en_q && auto_q && !busy && ((tsel_q == 3'd0) || sel_rise);
      start      = man_start || auto_start;
      if (first_now)      kind = K_FIRST;
      else if (man_start) kind = K_MAN;
      else                kind = K_AUTO;
      lock_now   = rd_en && (addr == A_LO);
      irq        = flag_q && ie_q;
   end

   sar_halftick #(.SEL_W(PS_W)) i_tick (
      .clk(clk), .rst_n(rst_n), .run(busy), .sel(psel_q), .tick(tick)
   );

   sar_engine #(
      .RES_W(RES_W), .CHAN_W(CHAN_W), .FIRST_HALF(FIRST_HALF),
      .AUTO_HALF(AUTO_HALF), .MAN_HALF(MAN_HALF)
   ) i_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .tick(tick),
      .cmp_in(cmp_in), .chan_req(chan_q), .busy(busy), .done(done),
      .code(dac_code), .chan_sel(chan_sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0; auto_q <= 1'b0; ie_q <= 1'b0; flag_q <= 1'b0;
         psel_q <= '0; tsel_q <= '0; chan_q <= '0; ladj_q <= 1'b0;
         res_q <= '0; locked_q <= 1'b0; first_q <= 1'b0; trig_prev <= '0;
      end else begin
         trig_prev <= trig_in;
         if (ctrl_wr) begin
            en_q   <= wdata[C_EN];
            auto_q <= wdata[C_AUTO];
            ie_q   <= wdata[C_IE];
            psel_q <= wdata[C_PS +: PS_W];
         end
         if (cfg_wr) begin
            chan_q <= wdata[CHAN_W-1:0];
            ladj_q <= wdata[F_LADJ];
            tsel_q <= wdata[F_TSEL +: 3];
         end
         if (start && !busy) first_q <= 1'b0;
         else if (en_rise)   first_q <= 1'b1;
         if (done)                           flag_q <= 1'b1;
         else if (ctrl_wr && wdata[C_FLAG])  flag_q <= 1'b0;
         if (done && !locked_q && !lock_now) res_q <= dac_code;
         if (rd_en && addr == A_HI)  locked_q <= 1'b0;
         else if (lock_now)          locked_q <= 1'b1;
      end
   end

   assign right_al = 16'(res_q);
   if (RES_W == 16) begin : g_full
      assign left_al = res_q;
   end else begin : g_pad
      assign left_al = {res_q, {(16 - RES_W){1'b0}}};
   end
   assign shown = ladj_q ? left_al : right_al;

   always_comb begin
      unique case (addr)
         A_CTRL:  rdata = {psel_q, ie_q, flag_q, auto_q, busy, en_q};
         A_CFG:   rdata = {tsel_q, ladj_q, 4'(chan_q)};
         A_LO:    rdata = shown[7:0];
         default: rdata = shown[15:8];
      endcase
   end

   // R8: the flag only rises as a conversion ends
   a_r8_flag_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(busy) && !busy);
   // R11: a locked result pair never changes
   a_r11_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> $stable(res_q));
endmodule

// File: tb/test_sar_conv_ctrl.sv
`timescale 1ns/1ps
module test_sar_conv_ctrl;
   localparam int RES_W = 10, CHAN_W = 4, N_TRIG = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [N_TRIG-1:0] trig_in = '0;
   logic [RES_W-1:0] dac_code;
   logic [CHAN_W-1:0] chan_sel;
   logic irq;
   logic [RES_W-1:0] ana = '0;
   logic cmp_in;
   int n_chk = 0, n_err = 0;

   always #2.5 clk = ~clk;
   assign cmp_in = (ana >= dac_code);

   sar_conv_ctrl #(.RES_W(RES_W), .CHAN_W(CHAN_W), .N_TRIG(N_TRIG)) i_sar_conv_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .trig_in(trig_in), .cmp_in(cmp_in),
      .dac_code(dac_code), .chan_sel(chan_sel), .irq(irq)
   );

   // {input[27:18], pad, left-align[16], expected high[15:8], expected low[7:0]}
   localparam logic [27:0] VEC [10] = '{
      {10'd0,    1'b0, 1'b0, 8'h00, 8'h00},
      {10'd1023, 1'b0, 1'b0, 8'h03, 8'hFF},
      {10'd512,  1'b0, 1'b0, 8'h02, 8'h00},
      {10'd511,  1'b0, 1'b1, 8'h7F, 8'hC0},
      {10'd725,  1'b0, 1'b1, 8'hB5, 8'h40},
      {10'd725,  1'b0, 1'b0, 8'h02, 8'hD5},
      {10'd1,    1'b0, 1'b1, 8'h00, 8'h40},
      {10'd341,  1'b0, 1'b0, 8'h01, 8'h55},
      {10'd682,  1'b0, 1'b1, 8'hAA, 8'h80},
      {10'd1023, 1'b0, 1'b1, 8'hFF, 8'hC0}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(posedge clk);
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic pulse(input int idx);
      @(negedge clk); trig_in[idx] = 1'b1;
      @(negedge clk); trig_in[idx] = 1'b0;
   endtask

   task automatic wait_irq(output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!irq && n < 2000);
   endtask

   task automatic idle_no_irq(input string tag);
      int seen = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (irq) seen = 1; end
      chk(tag, seen, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] d, h;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int a = 0; a < 4; a++) begin rd(2'(a), d); chk("R1 reg reset", d, 0); end
      chk("R1 irq reset", irq, 0);
      chk("R1 dac reset", dac_code, 0);
      chk("R1 chan reset", chan_sel, 0);

      // R3 first conversion, also R6/R7/R10
      ana = 10'd725;
      wr(2'd1, 8'h03);
      wr(2'd0, 8'h13);
      wait_irq(n); chk("R3 first length", n, 77);
      rd(2'd2, d); chk("R7 right low", d, 8'hD5);
      rd(2'd3, d); chk("R7 right high", d, 8'h02);
      chk("R10 chan latched", chan_sel, 3);
      wr(2'd0, 8'h19);
      rd(2'd0, d); chk("R8 flag cleared", d, 8'h11);

      // R2 R6 R7 table walk
      foreach (VEC[i]) begin
         ana = VEC[i][27:18];
         wr(2'd1, {3'd0, VEC[i][16], 4'd0});
         wr(2'd0, 8'h13);
         wait_irq(n); chk("R2 manual length", n, 29);
         rd(2'd2, d); chk("R6 R7 low byte", d, VEC[i][7:0]);
         rd(2'd3, d); chk("R6 R7 high byte", d, VEC[i][15:8]);
         wr(2'd0, 8'h19);
      end

      // R8 interrupt enable off: flag sets, irq stays low
      wr(2'd0, 8'h03);
      idle_no_irq("R8 irq masked");
      rd(2'd0, d); chk("R8 flag set", d, 8'h09);
      wr(2'd0, 8'h09);
      rd(2'd0, d); chk("R8 w1c", d, 8'h01);
      wr(2'd0, 8'h11);

      // R9 prescaler
      wr(2'd0, 8'h53);
      wait_irq(n); chk("R9 psel2 length", n, 116);
      wr(2'd0, 8'h19);

      // R2 busy readback and start ignored while busy
      wr(2'd0, 8'h13);
      rd(2'd0, d); chk("R2 start reads busy", d[1], 1);
      wr(2'd0, 8'h13);
      wait_irq(n);
      wr(2'd0, 8'h19);
      idle_no_irq("R2 start while busy ignored");
      rd(2'd0, d); chk("R2 start self-clears", d[1], 0);

      // R10 channel latch timing
      wr(2'd1, 8'h05);
      wr(2'd0, 8'h13);
      repeat (7) @(negedge clk); chk("R10 before sample", chan_sel, 0);
      @(negedge clk);            chk("R10 at sample", chan_sel, 5);
      wr(2'd1, 8'h09);
      wait_irq(n); chk("R10 late write held", chan_sel, 5);
      wr(2'd0, 8'h19);
      wr(2'd0, 8'h13);
      wait_irq(n); chk("R10 next conversion", chan_sel, 9);
      wr(2'd0, 8'h19);

      // R4 trigger select
      ana = 10'd300;
      wr(2'd1, 8'h40);
      wr(2'd0, 8'h15);
      pulse(0);
      idle_no_irq("R4 unselected trigger");
      pulse(1);
      wait_irq(n); chk("R4 trigger length", n, 31);
      rd(2'd2, d); rd(2'd3, h); chk("R4 R6 triggered result", {h, d}, 300);
      wr(2'd0, 8'h1D);
      pulse(1);
      repeat (5) @(negedge clk);
      pulse(1);
      wait_irq(n);
      wr(2'd0, 8'h1D);
      idle_no_irq("R4 trigger while busy ignored");
      wr(2'd1, 8'h60);
      pulse(0); pulse(1);
      idle_no_irq("R4 select beyond inputs");
      wr(2'd0, 8'h11);

      // R5 free-running
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h15);
      wait_irq(n); chk("R5 free first", n, 32);
      wr(2'd0, 8'h1D);
      wait_irq(n); chk("R5 free restart", n, 30);
      wr(2'd0, 8'h11);
      repeat (40) @(negedge clk);
      wr(2'd0, 8'h19);
      idle_no_irq("R5 stops when auto off");

      // R11 lock
      ana = 10'd100;
      wr(2'd0, 8'h13); wait_irq(n); wr(2'd0, 8'h19);
      rd(2'd2, d); chk("R11 low A", d, 8'h64);
      ana = 10'd900;
      wr(2'd0, 8'h13); wait_irq(n); wr(2'd0, 8'h19);
      rd(2'd3, d); chk("R11 high held", d, 0);
      rd(2'd2, d); chk("R11 low held", d, 8'h64);
      rd(2'd3, d);
      wr(2'd0, 8'h13); wait_irq(n); wr(2'd0, 8'h19);
      rd(2'd2, d); chk("R11 low after unlock", d, 8'h84);
      rd(2'd3, d); chk("R11 high after unlock", d, 3);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule